// File: doc/BRIEF.md
# Home Lease Library and Write-Delay Scheduler

This block sits at the home side of one cache slice and enforces coherence with leases instead of invalidations. For every line it owns, it remembers the latest expiry time it has promised to any reader. A reader gets the line's data with an expiry stamp and may keep its copy until that time. A writer must wait until every promise on the line has run out. Because of this, no sharer list and no invalidation traffic are needed. Writes happen only here, at the home level.

Two requesters, port 0 (local) and port 1 (remote), share one service slot, and a round-robin arbiter picks between them. A read is stamped with the current global time plus a programmable delta. A write to a line whose lease has not expired is parked in a single holding register. While it waits, reads keep being served, including reads of the same line. Those reads get the existing stamp back, so the wait never grows. The held write completes in the first cycle that the global time reaches the line's stamp.

A line that is not yet resident is fetched through a simple fill handshake. It arrives with a stamp of zero, which counts as already expired.

Top module: `lease_home`

## Requirements
- R1: After reset, rsp_valid, ack_valid, fill_req and both req_ready bits are low, and the delta equals DELTA_INIT (150).
- R2: A read of a resident line, with no held write on that line, is accepted with req_ready high. In the following cycle, rsp_valid is high and carries the line's data, rsp_port and a stamp of now + delta taken modulo 2^TW.
- R3: A read of the line that a held write is waiting on returns that line's stored stamp unchanged and the pre-write data.
- R4: A write is applied only when now is greater than or equal to the line's stored stamp. If the stamp has already expired at acceptance, ack_valid rises in the next cycle. Otherwise the write is held, and ack_valid rises in the cycle after the first cycle in which now reaches the stamp.
- R5: While a write is held, reads of any line are still accepted, including reads that arrive after the write.
- R6: Only one write can be held at a time. While it is held, any further write keeps req_ready low.
- R7: A request to a non-resident line raises fill_req with fill_line and keeps it high until fill_valid is seen. The line is then installed with fill_data and stamp zero, and the request is served afterwards. A write to a freshly filled line completes at any time value.
- R8: At most one request is accepted per cycle. When both ports are eligible, consecutive grants alternate between the ports.
- R9: A cycle with cfg_delta_we high loads cfg_delta, and later reads use the new delta.
- R10: The stored stamp of a line only grows. A read that issues a smaller stamp than the stored one leaves the stored stamp in place for later writes.
- R11: A held write is released in the same cycle that a read is presented. If the read is for the released line, it is stalled for one cycle and then returns the written data. If it is for another line, it is served in that same cycle, so ack_valid and rsp_valid rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TW (16) | Global time |
| cfg_delta_we | input | 1 | Load strobe for the lease delta |
| cfg_delta | input | TW (16) | New lease delta |
| req_valid | input | 2 | Request present, one bit per port |
| req_write | input | 2 | 1 = write, 0 = read, per port |
| req_line | input | 2 x LW (3) | Line index, per port |
| req_data | input | 2 x DW (16) | Write data, per port |
| req_ready | output | 2 | Request accepted this cycle, per port |
| fill_req | output | 1 | Fill of a non-resident line requested |
| fill_line | output | LW (3) | Line being filled |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DW (16) | Fill data |
| rsp_valid | output | 1 | Read response valid |
| rsp_port | output | 1 | Port the response belongs to |
| rsp_line | output | LW (3) | Line read |
| rsp_data | output | DW (16) | Line data |
| rsp_stamp | output | TW (16) | Lease expiry issued |
| ack_valid | output | 1 | Write acknowledgement valid |
| ack_port | output | 1 | Port the write came from |
| ack_line | output | LW (3) | Line written |

## Verification
Two things can land in the same cycle: the release of a held write when its lease runs out, and the service of a fresh read. The bench sets up this collision by moving the time to the stamp in the same cycle that it presents one read of the held line and one read of another line. It then expects exactly three results. The other-line read is served alongside the acknowledgement. The held-line read waits one cycle. That delayed read then returns the newly written data with a freshly issued stamp.

// File: rtl/lease_home.sv
`timescale 1ns/1ps
module lease_home #(
  parameter int NLINES     = 8,
  parameter int DW         = 16,
  parameter int TW         = 16,
  parameter int DELTA_INIT = 150,
  localparam int LW = $clog2(NLINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TW-1:0]         now,
  input  logic                  cfg_delta_we,
  input  logic [TW-1:0]         cfg_delta,
  input  logic [1:0]            req_valid,
  input  logic [1:0]            req_write,
  input  logic [1:0][LW-1:0]    req_line,
  input  logic [1:0][DW-1:0]    req_data,
  output logic [1:0]            req_ready,
  output logic                  fill_req,
  output logic [LW-1:0]         fill_line,
  input  logic                  fill_valid,
  input  logic [DW-1:0]         fill_data,
  output logic                  rsp_valid,
  output logic                  rsp_port,
  output logic [LW-1:0]         rsp_line,
  output logic [DW-1:0]         rsp_data,
  output logic [TW-1:0]         rsp_stamp,
  output logic                  ack_valid,
  output logic                  ack_port,
  output logic [LW-1:0]         ack_line
);

  logic [NLINES-1:0]          res_q;
  logic [NLINES-1:0][DW-1:0]  data_q;
  logic [NLINES-1:0][TW-1:0]  stamp_q;
  logic [TW-1:0]              delta_q;
  logic                       hold_valid, hold_port;
  logic [LW-1:0]              hold_line;
  logic [DW-1:0]              hold_data;
  logic                       fill_busy;
  logic [LW-1:0]              fill_line_q;
  logic                       rr_q;

  logic        rel;
  logic [1:0]  elig;
  logic        pref, gnt_any, gnt_id;
  logic [LW-1:0] g_line;
  logic        g_res, g_wr, g_exp, acc, miss, hold_on_line;
  logic        wr_now, wr_park, rd_now;
  logic [TW-1:0] new_stamp, issued;

  assign rel = hold_valid && (now >= stamp_q[hold_line]);

  for (genvar i = 0; i < 2; i++) begin : g_elig
    assign elig[i] = req_valid[i] && !fill_busy
                   && !(rel && req_line[i] == hold_line)
                   && !(req_write[i] && hold_valid);
    assign req_ready[i] = acc && (gnt_id == i[0]);
  end

  assign pref    = ~rr_q;
  assign gnt_any = |elig;
  assign gnt_id  = elig[pref] ? pref : ~pref;
  assign g_line  = req_line[gnt_id];
  assign g_wr    = req_write[gnt_id];
  assign g_res   = res_q[g_line];
  assign g_exp   = now >= stamp_q[g_line];
  assign acc     = gnt_any && g_res;
  assign miss    = gnt_any && !g_res;

  assign hold_on_line = hold_valid && (hold_line == g_line);
  assign new_stamp    = now + delta_q;
  assign issued       = hold_on_line ? stamp_q[g_line] : new_stamp;

  assign rd_now  = acc && !g_wr;
  assign wr_now  = acc && g_wr && g_exp;
  assign wr_park = acc && g_wr && !g_exp;

  assign fill_req  = fill_busy;
  assign fill_line = fill_line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q      <= '0;
      data_q     <= '0;
      stamp_q    <= '0;
      delta_q    <= TW'(DELTA_INIT);
      hold_valid <= 1'b0;
      hold_port  <= 1'b0;
      hold_line  <= '0;
      hold_data  <= '0;
      fill_busy  <= 1'b0;
      fill_line_q <= '0;
      rr_q       <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_port   <= 1'b0;
      rsp_line   <= '0;
      rsp_data   <= '0;
      rsp_stamp  <= '0;
      ack_valid  <= 1'b0;
      ack_port   <= 1'b0;
      ack_line   <= '0;
    end else begin
      rsp_valid <= rd_now;
      ack_valid <= wr_now || rel;
      if (cfg_delta_we) delta_q <= cfg_delta;
      if (acc) rr_q <= gnt_id;

      if (rd_now) begin
        rsp_port  <= gnt_id;
        rsp_line  <= g_line;
        rsp_data  <= data_q[g_line];
        rsp_stamp <= issued;
        if (!hold_on_line && new_stamp > stamp_q[g_line])
          stamp_q[g_line] <= new_stamp;
      end

      if (wr_now) begin
        data_q[g_line] <= req_data[gnt_id];
        ack_port <= gnt_id;
        ack_line <= g_line;
      end

      if (wr_park) begin
        hold_valid <= 1'b1;
        hold_port  <= gnt_id;
        hold_line  <= g_line;
        hold_data  <= req_data[gnt_id];
      end

      if (rel) begin
        data_q[hold_line] <= hold_data;
        hold_valid <= 1'b0;
        ack_port   <= hold_port;
        ack_line   <= hold_line;
      end

      if (miss) begin
        fill_busy   <= 1'b1;
        fill_line_q <= g_line;
      end

      if (fill_busy && fill_valid) begin
        res_q[fill_line_q]   <= 1'b1;
        data_q[fill_line_q]  <= fill_data;
        stamp_q[fill_line_q] <= '0;
        fill_busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lease_home_chk.sv
`timescale 1ns/1ps
module lease_home_chk #(
  parameter int NLINES = 8,
  parameter int TW     = 16,
  localparam int LW = $clog2(NLINES)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [TW-1:0]             now,
  input logic [1:0]                req_valid,
  input logic [1:0]                req_ready,
  input logic                      fill_req,
  input logic                      fill_valid,
  input logic                      ack_valid,
  input logic                      hold_valid,
  input logic [LW-1:0]             hold_line,
  input logic [NLINES-1:0][TW-1:0] stamp_q
);
  logic [TW-1:0] held_stamp;
  assign held_stamp = stamp_q[hold_line];

  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == 2'b00);

  a_r7_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req);

  a_r3_stamp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid && $past(hold_valid) |-> $stable(held_stamp));

  a_r4_release_expired: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && $past(hold_valid) && !hold_valid |-> $past(now) >= $past(held_stamp));
endmodule

bind lease_home lease_home_chk #(.NLINES(NLINES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .now(now), .req_valid(req_valid),
  .req_ready(req_ready), .fill_req(fill_req), .fill_valid(fill_valid),
  .ack_valid(ack_valid), .hold_valid(hold_valid), .hold_line(hold_line),
  .stamp_q(stamp_q));

// File: tb/lease_home_bench.sv
`timescale 1ns/1ps
module lease_home_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] now = '0;
  logic cfg_delta_we = 1'b0;
  logic [15:0] cfg_delta = '0;
  logic [1:0] req_valid = '0, req_write = '0;
  logic [1:0][2:0] req_line = '0;
  logic [1:0][15:0] req_data = '0;
  logic [1:0] req_ready;
  logic fill_req, fill_valid = 1'b0;
  logic [2:0] fill_line;
  logic [15:0] fill_data = '0;
  logic rsp_valid, rsp_port, ack_valid, ack_port;
  logic [2:0] rsp_line, ack_line;
  logic [15:0] rsp_data, rsp_stamp;

  int n_chk = 0, n_fail = 0, n_fill = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lease_home u_lease_home (
    .clk(clk), .rst_n(rst_n), .now(now), .cfg_delta_we(cfg_delta_we),
    .cfg_delta(cfg_delta), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .req_data(req_data), .req_ready(req_ready),
    .fill_req(fill_req), .fill_line(fill_line), .fill_valid(fill_valid),
    .fill_data(fill_data), .rsp_valid(rsp_valid), .rsp_port(rsp_port),
    .rsp_line(rsp_line), .rsp_data(rsp_data), .rsp_stamp(rsp_stamp),
    .ack_valid(ack_valid), .ack_port(ack_port), .ack_line(ack_line));

  initial forever begin
    @(negedge clk);
    if (fill_req && !fill_valid) n_fill++;
    fill_valid <= fill_req && !fill_valid;
    fill_data  <= 16'hF000 | 16'(fill_line);
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(int p, bit w, int line, logic [15:0] d, string req);
    bit got = 0;
    req_write[p] = w; req_line[p] = 3'(line); req_data[p] = d; req_valid[p] = 1'b1;
    for (int k = 0; k < 50 && !got; k++) begin
      #1;
      if (req_ready[p]) begin
        @(posedge clk); @(negedge clk);
        got = 1;
      end else @(negedge clk);
    end
    req_valid[p] = 1'b0;
    check(got, req, 0, 1);
  endtask

  typedef struct packed {
    logic p; logic w; logic [2:0] line; logic [15:0] d; logic [15:0] t;
    logic [15:0] ed; logic [15:0] es;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 3'd2, 16'h0000, 16'd1000, 16'hF002, 16'd1150},
    '{1'b0, 1'b0, 3'd2, 16'h0000, 16'd1100, 16'hF002, 16'd1250},
    '{1'b0, 1'b1, 3'd2, 16'hAAAA, 16'd1300, 16'h0000, 16'd0},
    '{1'b1, 1'b0, 3'd2, 16'h0000, 16'd1300, 16'hAAAA, 16'd1450},
    '{1'b1, 1'b1, 3'd5, 16'h5555, 16'd10,   16'h0000, 16'd0},
    '{1'b0, 1'b0, 3'd5, 16'h0000, 16'd20,   16'h5555, 16'd170}
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f0, w1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!rsp_valid && !ack_valid && !fill_req && req_ready == 2'b00, "R1 idle", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R7 vectors
    foreach (VEC[i]) begin
      now = VEC[i].t;
      issue(int'(VEC[i].p), VEC[i].w, int'(VEC[i].line), VEC[i].d, "R2 accept");
      if (VEC[i].w) begin
        check(ack_valid && ack_port == VEC[i].p && ack_line == VEC[i].line,
              "R4 R7 immediate ack", int'(ack_valid), 1);
      end else begin
        check(rsp_valid && rsp_port == VEC[i].p && rsp_data == VEC[i].ed,
              "R2 read data", int'(rsp_data), int'(VEC[i].ed));
        check(rsp_stamp == VEC[i].es, "R2 stamp", int'(rsp_stamp), int'(VEC[i].es));
      end
    end

    // R7 fill then R9 R10
    f0 = n_fill;
    now = 500;
    issue(0, 0, 6, 0, "R7 accept");
    check(n_fill == f0 + 1, "R7 one fill", n_fill - f0, 1);
    check(rsp_data == 16'hF006 && rsp_stamp == 650, "R7 filled read", int'(rsp_stamp), 650);
    cfg_delta_we = 1'b1; cfg_delta = 40;
    @(negedge clk); cfg_delta_we = 1'b0;
    now = 560;
    issue(1, 0, 6, 0, "R9 accept");
    check(rsp_stamp == 600, "R9 new delta", int'(rsp_stamp), 600);
    now = 620;
    issue(0, 1, 6, 16'hBEEF, "R10 accept");
    check(!ack_valid, "R10 write held by older max", int'(ack_valid), 0);
    now = 649; @(negedge clk);
    check(!ack_valid, "R4 not before stamp", int'(ack_valid), 0);
    now = 650; @(negedge clk);
    check(ack_valid && ack_line == 6 && ack_port == 0, "R4 release at stamp", int'(ack_valid), 1);
    @(negedge clk);
    issue(1, 0, 6, 0, "R4 accept");
    check(rsp_data == 16'hBEEF, "R4 data written", int'(rsp_data), 16'hBEEF);

    // R3 R5 R6 blocked write
    now = 2000;
    issue(0, 0, 3, 0, "R3 accept");
    check(rsp_stamp == 2040, "R3 setup stamp", int'(rsp_stamp), 2040);
    now = 2010;
    issue(0, 1, 3, 16'h1234, "R3 write accept");
    check(!ack_valid, "R3 write held", int'(ack_valid), 0);
    issue(1, 0, 3, 0, "R5 accept");
    check(rsp_stamp == 2040 && rsp_data == 16'hF003, "R3 frozen stamp", int'(rsp_stamp), 2040);
    issue(1, 0, 2, 0, "R5 accept other");
    check(rsp_data == 16'hAAAA && rsp_stamp == 2050, "R5 bypass read", int'(rsp_stamp), 2050);
    req_write[1] = 1'b1; req_line[1] = 3'd4; req_data[1] = 16'h4444; req_valid[1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!req_ready[1], "R6 second write refused", int'(req_ready[1]), 0);
      @(negedge clk);
    end
    req_valid[1] = 1'b0;
    now = 2039; @(negedge clk);
    check(!ack_valid, "R4 held before stamp", int'(ack_valid), 0);

    // R11 release and reads in the same cycle
    now = 2040;
    req_write = 2'b00; req_line[0] = 3'd3; req_line[1] = 3'd2; req_valid = 2'b11;
    #1;
    check(req_ready == 2'b10, "R11 held line stalls", int'(req_ready), 2);
    @(posedge clk); @(negedge clk);
    req_valid[1] = 1'b0;
    check(ack_valid && ack_line == 3 && rsp_valid && rsp_port == 1,
          "R11 ack with other read", int'({ack_valid, rsp_valid}), 3);
    #1;
    check(req_ready[0], "R11 stalled read next", int'(req_ready[0]), 1);
    @(posedge clk); @(negedge clk);
    req_valid[0] = 1'b0;
    check(rsp_data == 16'h1234 && rsp_stamp == 2080 && rsp_port == 0,
          "R11 written data", int'(rsp_data), 16'h1234);

    // R8 fairness
    for (int r = 0; r < 2; r++) begin
      req_write = 2'b00; req_line[0] = 3'd2; req_line[1] = 3'd5; req_valid = 2'b11;
      #1;
      check($countones(req_ready) == 1, "R8 one grant", $countones(req_ready), 1);
      w1 = req_ready[1] ? 1 : 0;
      @(posedge clk); @(negedge clk);
      req_valid[w1] = 1'b0;
      check(rsp_valid && rsp_port == w1[0], "R8 first response", int'(rsp_port), w1);
      #1;
      check(req_ready[1 - w1], "R8 alternate grant", int'(req_ready), 1 << (1 - w1));
      @(posedge clk); @(negedge clk);
      req_valid = 2'b00;
      check(rsp_valid && rsp_port == !w1[0], "R8 second response", int'(rsp_port), 1 - w1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule